// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is one DMA channel that fetches a contiguous range of memory, one data word at a time, and emits it as a byte-counted stream with valid, ready, data, keep and last. Software sets it up through a small word-addressed register port. The port holds four registers: control, status, source address and byte length. The write to the length register is the trigger for a transfer. The channel runs the transfer only if its run bit is already set and no transfer is in flight. The control and source-address registers can be written in either order before that write.

Memory is read through a request/response port that has one read outstanding at a time. Each accepted request returns one word, and that word may carry an error flag. The channel counts the bytes left, so the final beat can be partial. There is a done interrupt and an error interrupt. Each is a level output, gated by its own enable and cleared by a write-one-to-clear of its status flag.

Top module: `m2s_dma`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x3 (halted and idle), and s_valid, mem_req_valid, irq_done and irq_err are all low.
- R2: A length write with run set, the channel idle and a non-zero length starts a transfer. The channel fetches words from consecutive aligned addresses. The first address is the source address with its low log2(DATA_W/8) bits cleared, and each later address is 4 higher (default width). Each word is sent as one beat, in fetch order. A memory request holds its address until it is accepted.
- R3: While run is 0 (halted), a length write starts nothing, issues no memory request and sets the error-pending flag.
- R4: A length write while a transfer is busy, or a length of zero, is ignored (the length readback keeps the accepted value) and sets the error-pending flag. A running transfer is not disturbed.
- R5: keep bit i covers byte lane i, which is data bits 8i+7:8i. Every beat except the last has keep all ones. The last beat has s_last high. On that beat keep has the low (length mod 4) bits set, or all bits when the length is a multiple of 4. After the last beat is accepted, s_valid is low on the next cycle.
- R6: While s_valid is high and s_ready is low, s_valid, s_data, s_keep and s_last hold their values.
- R7: A read response with mem_rsp_err high ends the transfer. That word and all later bytes are not sent, the error-pending flag is set, done is not set and the channel returns to idle.
- R8: Acceptance of the last beat sets done-pending (status bit 2). irq_done equals done-pending AND the done enable (control bit 1). Writing status with bit 2 set clears the flag.
- R9: irq_err equals error-pending (status bit 3) AND the error enable (control bit 2). Writing status with bit 3 set clears the flag.
- R10: If run is cleared during a transfer, the beat already being fetched or held is delivered. The channel then stops with no done flag, and the status reads halted (bit 0) and idle (bit 1).
- R11: Register offsets are 0x0 control (bit 0 run, bit 1 done enable, bit 2 error enable), 0x4 status (bit 0 halted, bit 1 idle), 0x8 source address and 0xC length. The control and source registers read back their written values, and the length register reads back the last accepted length. A write is decoded only when address bits 1:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Word-aligned read byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DATA_W | Read response word |
| mem_rsp_err | input | 1 | Read response error flag |
| s_valid | output | 1 | Stream beat valid |
| s_ready | input | 1 | Stream beat accepted |
| s_data | output | DATA_W | Stream data |
| s_keep | output | DATA_W/8 | Byte-lane enables |
| s_last | output | 1 | Final beat of the transfer |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The embedded assertions check on every cycle that a stalled stream beat holds still and that a pending memory request keeps its address. They also check that nothing is valid in the cycle after a last beat, that a launch never reaches a busy engine, and that every rejected length write raises the error flag. The bench scenarios cover what needs whole transfers. These are the data order and the partial keep values for several lengths, a memory fault that cuts a transfer short, and a stop with run cleared that delivers exactly one held beat. They also cover the interrupt gating and clearing as seen from the register port.

// File: rtl/dma_m2s_pkg.sv
// Shared types and register-map constants for the memory-to-stream DMA channel.
// Assumes a 32-bit register port with word offsets decoded from address bits 3:2.
package dma_m2s_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEND = 2'd3
    } eng_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_SRC  = 2'd2;
    localparam logic [1:0] REG_LEN  = 2'd3;

    localparam int unsigned CTRL_RUN     = 0;
    localparam int unsigned CTRL_DONE_IE = 1;
    localparam int unsigned CTRL_ERR_IE  = 2;

    localparam int unsigned STAT_HALT = 0;
    localparam int unsigned STAT_IDLE = 1;
    localparam int unsigned STAT_DONE = 2;
    localparam int unsigned STAT_ERR  = 3;

endpackage

// File: rtl/dma_m2s_lanes.sv
// Byte-lane mask and last-beat flag from the count of bytes still to send.
// Assumes rem_i is non-zero whenever the result is used.
module dma_m2s_lanes #(
    parameter int BYTES = 4,
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] rem_i,
    output logic [BYTES-1:0] keep_o,
    output logic             last_o
);

    // One comparator per byte lane: the lane is live while bytes remain beyond it.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign keep_o[i] = (rem_i > LEN_W'(i));
    end

    // The beat is the final one when it can hold every remaining byte.
    assign last_o = (rem_i <= LEN_W'(BYTES));

endmodule

// File: rtl/dma_m2s_regs.sv
// Register file: control, write-one-to-clear status, source address and length.
// Decides whether a length write launches a transfer or is rejected with an error.
// Assumes ADDR_W and LEN_W do not exceed 32 and single-cycle writes.
module dma_m2s_regs
    import dma_m2s_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              err_i,
    output logic              run_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              start_o,
    output logic              irq_done_o,
    output logic              irq_err_o
);

    localparam int BYTES = DATA_W / 8;
    localparam int OFS   = $clog2(BYTES);

    logic              run_q, done_ie_q, err_ie_q;
    logic              done_pend_q, err_pend_q;
    logic [ADDR_W-1:0] src_q;
    logic [LEN_W-1:0]  len_q;
    logic              hit, wr_ctrl, wr_stat, wr_src, wr_len, len_ok, reject;

    // Write decode: only word-aligned offsets select a register.
    assign hit     = we && (addr[1:0] == 2'b00);
    assign wr_ctrl = hit && (addr[3:2] == REG_CTRL);
    assign wr_stat = hit && (addr[3:2] == REG_STAT);
    assign wr_src  = hit && (addr[3:2] == REG_SRC);
    assign wr_len  = hit && (addr[3:2] == REG_LEN);

    // Launch qualification: running, idle and a non-zero byte count.
    assign len_o   = wdata[LEN_W-1:0];
    assign len_ok  = run_q && !busy_i && (len_o != '0);
    assign start_o = wr_len && len_ok;
    assign reject  = wr_len && !len_ok;

    assign run_o      = run_q;
    assign src_o      = {src_q[ADDR_W-1:OFS], {OFS{1'b0}}};
    assign irq_done_o = done_pend_q && done_ie_q;
    assign irq_err_o  = err_pend_q && err_ie_q;

    // Register updates, pending flags set by events and cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            done_ie_q   <= 1'b0;
            err_ie_q    <= 1'b0;
            done_pend_q <= 1'b0;
            err_pend_q  <= 1'b0;
            src_q       <= '0;
            len_q       <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q     <= wdata[CTRL_RUN];
                done_ie_q <= wdata[CTRL_DONE_IE];
                err_ie_q  <= wdata[CTRL_ERR_IE];
            end
            if (wr_src) begin
                src_q <= wdata[ADDR_W-1:0];
            end
            if (start_o) begin
                len_q <= len_o;
            end
            if (done_i) begin
                done_pend_q <= 1'b1;
            end else if (wr_stat && wdata[STAT_DONE]) begin
                done_pend_q <= 1'b0;
            end
            if (reject || err_i) begin
                err_pend_q <= 1'b1;
            end else if (wr_stat && wdata[STAT_ERR]) begin
                err_pend_q <= 1'b0;
            end
        end
    end

    // Read mux, zero-extended to the port width.
    always_comb begin
        rdata = '0;
        case (addr[3:2])
            REG_CTRL: begin
                rdata[CTRL_RUN]     = run_q;
                rdata[CTRL_DONE_IE] = done_ie_q;
                rdata[CTRL_ERR_IE]  = err_ie_q;
            end
            REG_STAT: begin
                rdata[STAT_HALT] = !run_q && !busy_i;
                rdata[STAT_IDLE] = !busy_i;
                rdata[STAT_DONE] = done_pend_q;
                rdata[STAT_ERR]  = err_pend_q;
            end
            REG_SRC: rdata[ADDR_W-1:0] = src_q;
            default: rdata[LEN_W-1:0]  = len_q;
        endcase
    end

    // R3 and R4: every refused length write leaves the error flag raised.
    p_reject_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len && (busy_i || !run_q || (len_o == '0))) |=> err_pend_q);

endmodule

// File: rtl/dma_m2s_engine.sv
// Transfer sequencer: one read outstanding, one word per beat, byte countdown.
// Stops after the current beat when run drops; aborts on a read error.
// Assumes start_i is only presented while idle and responses come only after a request.
module dma_m2s_engine
    import dma_m2s_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                run_i,
    input  logic [ADDR_W-1:0]   src_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                s_valid,
    input  logic                s_ready,
    output logic [DATA_W-1:0]   s_data,
    output logic [DATA_W/8-1:0] s_keep,
    output logic                s_last
);

    localparam int BYTES = DATA_W / 8;

    eng_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [DATA_W-1:0] data_q;
    logic              last_w;
    logic              beat_take;

    dma_m2s_lanes #(.BYTES(BYTES), .LEN_W(LEN_W)) lanes_i (
        .rem_i  (rem_q),
        .keep_o (s_keep),
        .last_o (last_w)
    );

    assign busy_o        = (state_q != ST_IDLE);
    assign mem_req_valid = (state_q == ST_REQ);
    assign mem_req_addr  = addr_q;
    assign s_valid       = (state_q == ST_SEND);
    assign s_data        = data_q;
    assign s_last        = last_w;
    assign beat_take     = s_valid && s_ready;
    assign done_o        = beat_take && last_w;
    assign err_o         = (state_q == ST_WAIT) && mem_rsp_valid && mem_rsp_err;

    // Sequencing: fetch, wait, present, then advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q  <= src_i;
                        rem_q   <= len_i;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            state_q <= ST_IDLE;
                        end else begin
                            data_q  <= mem_rsp_data;
                            state_q <= ST_SEND;
                        end
                    end
                end
                default: begin
                    if (s_ready) begin
                        if (last_w || !run_i) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_REQ;
                        end
                        addr_q <= addr_q + ADDR_W'(BYTES);
                        rem_q  <= rem_q - LEN_W'(BYTES);
                    end
                end
            endcase
        end
    end

    // R6: a stalled beat does not move.
    p_stream_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_data) && $stable(s_keep) && $stable(s_last)));

    // R2: an unaccepted read request keeps its address.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5: nothing follows an accepted last beat in the next cycle.
    p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> !s_valid);

    // R4: the register file never launches into a busy engine.
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/m2s_dma.sv
// Top of the memory-to-stream DMA channel: register file plus transfer engine.
// Assumes DATA_W is a power-of-two multiple of 8 and ADDR_W, LEN_W are at most 32.
module m2s_dma #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                s_valid,
    input  logic                s_ready,
    output logic [DATA_W-1:0]   s_data,
    output logic [DATA_W/8-1:0] s_keep,
    output logic                s_last,
    output logic                irq_done,
    output logic                irq_err
);

    logic              busy, done_evt, err_evt, run, start;
    logic [ADDR_W-1:0] src_word;
    logic [LEN_W-1:0]  len_val;

    dma_m2s_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy_i     (busy),
        .done_i     (done_evt),
        .err_i      (err_evt),
        .run_o      (run),
        .src_o      (src_word),
        .len_o      (len_val),
        .start_o    (start),
        .irq_done_o (irq_done),
        .irq_err_o  (irq_err)
    );

    dma_m2s_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) engine_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .run_i         (run),
        .src_i         (src_word),
        .len_i         (len_val),
        .busy_o        (busy),
        .done_o        (done_evt),
        .err_o         (err_evt),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .s_valid       (s_valid),
        .s_ready       (s_ready),
        .s_data        (s_data),
        .s_keep        (s_keep),
        .s_last        (s_last)
    );

endmodule

// File: tb/m2s_dma_tb_top.sv
// Scoreboard bench: the driver queues expected beats, a monitor pops and compares them.
// 250 MHz clock (4 time-unit period); inputs change 1 unit after a rising edge, sampling on falling edges.
module m2s_dma_tb_top;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  keep;
        logic        last;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'h0;
    logic        mem_rsp_err = 1'b0;
    logic        s_valid;
    logic        s_ready = 1'b0;
    logic [31:0] s_data;
    logic [3:0]  s_keep;
    logic        s_last;
    logic        irq_done;
    logic        irq_err;

    int    checks = 0;
    int    errors = 0;
    int    rdy_mode = 0;
    logic  mem_stall = 1'b0;
    logic  err_armed = 1'b0;
    logic [31:0] err_addr = 32'h0;
    int    mem_takes = 0;
    beat_t exp_q[$];

    always #2 clk = ~clk;

    m2s_dma #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A00_0000;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push_expect(input logic [31:0] src, input int len, input int limit);
        logic [31:0] base;
        base = {src[31:2], 2'b00};
        for (int i = 0; i * 4 < len && i < limit; i++) begin
            beat_t b;
            int rem;
            rem = len - 4 * i;
            b.data = mem_word(base + 32'(4 * i));
            b.keep = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
            b.last = (rem <= 4);
            exp_q.push_back(b);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] st;
        for (int n = 0; n < 3000; n++) begin
            reg_rd(4'h4, st);
            if (st[1]) return;
        end
        check(tag, "idle timeout", 32'h0, 32'h1);
    endtask

    task automatic queue_empty(input string tag);
        check(tag, "beats left in scoreboard", 32'(exp_q.size()), 32'h0);
    endtask

    // Memory model: samples a request on the falling edge, answers in the next cycle.
    initial begin
        logic        take;
        logic [31:0] a;
        int          cyc;
        cyc = 0;
        forever begin
            @(negedge clk);
            take = mem_req_valid && mem_req_ready;
            a = mem_req_addr;
            cyc++;
            @(posedge clk); #1;
            if (take) mem_takes++;
            mem_rsp_valid = take;
            mem_rsp_data  = take ? mem_word(a) : 32'h0;
            mem_rsp_err   = take && err_armed && (a == err_addr);
            mem_req_ready = mem_stall ? cyc[0] : 1'b1;
        end
    end

    // Stream sink ready pattern: always, alternating, or held low.
    initial begin
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0:       s_ready = 1'b1;
                1:       s_ready = ~s_ready;
                default: s_ready = 1'b0;
            endcase
        end
    end

    // Monitor: pops the scoreboard on each handshake and watches stalled beats.
    initial begin
        beat_t prev;
        logic  prev_hold;
        prev = '0;
        prev_hold = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev_hold) begin
                check("R6", "stalled beat held", {s_data ^ prev.data, 3'b0, s_valid, s_keep, s_last},
                      {32'h0, 3'b0, 1'b1, prev.keep, prev.last});
            end
            if (rst_n && s_valid && s_ready) begin
                if (exp_q.size() == 0) begin
                    check("R2", "unexpected beat data", s_data, 32'hxxxx_xxxx);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check("R2", "beat data", s_data, e.data);
                    check("R5", "beat keep", 32'(s_keep), 32'(e.keep));
                    check("R5", "beat last", 32'(s_last), 32'(e.last));
                end
            end
            prev_hold = s_valid && !s_ready;
            prev = {s_data, s_keep, s_last};
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          takes0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        reg_rd(4'h4, rd); check("R1", "status after reset", rd, 32'h3);
        reg_rd(4'h0, rd); check("R1", "control after reset", rd, 32'h0);
        check("R1", "outputs after reset", {28'h0, s_valid, mem_req_valid, irq_done, irq_err}, 32'h0);

        // R2 and R11: source before control, full-word transfer
        reg_wr(4'h8, 32'h0000_0100);
        reg_wr(4'h0, 32'h3);
        reg_rd(4'h0, rd); check("R11", "control readback", rd, 32'h3);
        reg_rd(4'h8, rd); check("R11", "source readback", rd, 32'h0000_0100);
        push_expect(32'h100, 8, 99);
        reg_wr(4'hC, 32'd8);
        wait_idle("R2");
        queue_empty("R2");
        reg_rd(4'h4, rd); check("R8", "status done pending", rd, 32'h6);
        check("R8", "irq_done raised", 32'(irq_done), 32'h1);
        reg_wr(4'h4, 32'h4);
        check("R8", "irq_done cleared", 32'(irq_done), 32'h0);
        reg_rd(4'h4, rd); check("R8", "status after clear", rd, 32'h2);

        // R5 and R6: partial tail with alternating ready, unaligned source
        rdy_mode = 1;
        reg_wr(4'h8, 32'h0000_0202);
        push_expect(32'h202, 7, 99);
        reg_wr(4'hC, 32'd7);
        wait_idle("R5");
        queue_empty("R5");
        reg_rd(4'hC, rd); check("R11", "length readback", rd, 32'd7);
        reg_wr(4'h4, 32'h4);

        // R5: single partial beat and five bytes with a stalling memory
        rdy_mode = 0;
        mem_stall = 1'b1;
        reg_wr(4'h8, 32'h0000_0240);
        push_expect(32'h240, 5, 99);
        reg_wr(4'hC, 32'd5);
        wait_idle("R5");
        push_expect(32'h240, 1, 99);
        reg_wr(4'hC, 32'd1);
        wait_idle("R5");
        queue_empty("R5");
        mem_stall = 1'b0;
        reg_wr(4'h4, 32'h4);

        // R4 and R9: zero length rejected, interrupt gated by its enable
        takes0 = mem_takes;
        reg_wr(4'hC, 32'd0);
        reg_rd(4'h4, rd); check("R4", "zero length sets error", rd, 32'hA);
        check("R4", "zero length issues no read", 32'(mem_takes - takes0), 32'h0);
        check("R9", "irq_err masked", 32'(irq_err), 32'h0);
        reg_wr(4'h0, 32'h7);
        check("R9", "irq_err enabled", 32'(irq_err), 32'h1);
        reg_wr(4'h4, 32'h8);
        check("R9", "irq_err cleared", 32'(irq_err), 32'h0);

        // R4: length write while busy is ignored
        rdy_mode = 2;
        reg_wr(4'h8, 32'h0000_0300);
        push_expect(32'h300, 16, 99);
        reg_wr(4'hC, 32'd16);
        repeat (4) @(posedge clk);
        reg_wr(4'hC, 32'd4);
        reg_rd(4'h4, rd); check("R4", "busy write sets error", rd & 32'hA, 32'h8);
        rdy_mode = 0;
        wait_idle("R4");
        queue_empty("R4");
        reg_rd(4'hC, rd); check("R4", "length kept", rd, 32'd16);
        reg_wr(4'h4, 32'hC);

        // R7: read error on the third word cuts the transfer
        err_armed = 1'b1;
        err_addr = 32'h0000_0408;
        reg_wr(4'h8, 32'h0000_0400);
        push_expect(32'h400, 16, 2);
        reg_wr(4'hC, 32'd16);
        wait_idle("R7");
        queue_empty("R7");
        reg_rd(4'h4, rd); check("R7", "error set, done clear", rd & 32'hC, 32'h8);
        check("R7", "irq_err on fault", 32'(irq_err), 32'h1);
        err_armed = 1'b0;
        reg_wr(4'h4, 32'hC);

        // R10: clear run while the first beat is held
        rdy_mode = 2;
        reg_wr(4'h8, 32'h0000_0500);
        push_expect(32'h500, 16, 1);
        reg_wr(4'hC, 32'd16);
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (s_valid) break;
        end
        reg_wr(4'h0, 32'h6);
        rdy_mode = 0;
        wait_idle("R10");
        queue_empty("R10");
        reg_rd(4'h4, rd); check("R10", "halted status", rd, 32'h3);
        check("R10", "no done interrupt", 32'(irq_done), 32'h0);

        // R3: length write while halted
        takes0 = mem_takes;
        reg_wr(4'hC, 32'd4);
        repeat (4) @(posedge clk);
        reg_rd(4'h4, rd); check("R3", "halted write sets error", rd, 32'hB);
        check("R3", "no read while halted", 32'(mem_takes - takes0), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule